// File: doc/BRIEF.md
# Synchronous Bus Clock-Enable Prescaler

This block produces clock-enable pulses for four synchronous domains from one main clock: the processor core, the high-speed bus, and two peripheral buses (A and B). Each domain either runs at the main rate or at the main rate divided by a power of two. A per-domain mask then turns that domain's enable into one gated enable for each attached module. Downstream logic uses these pulses as flop enables, so no derived clocks exist and the whole chip stays on one clock net.

The main clock is qualified by one of two tick inputs. One comes from the oscillator path and one from the PLL path, and a register bit chooses between them. All dividers share one free-running counter that advances on each main tick. Because of this, a slower domain's pulse always lines up with a pulse of every faster domain. Software programs the ratios and masks through a single-cycle register port. A ratio write that would make a child domain faster than its parent is refused.

Top module: `sync_clk_prescaler`

## Requirements
- R1: After reset, the divide control reads 0 at address 0, the source/status register reads 0 at address 1, and every mask register (addresses 2 to 5) reads 0xFFFFFFFF. With the oscillator tick high, all four `dom_en` bits and all 128 `mod_en` bits are 1 in the first cycle after reset.
- R2: A domain whose divide-enable bit is clear pulses in every cycle where the selected main tick is high. No `dom_en` bit is ever high in a cycle where the selected main tick is low.
- R3: The divide control at address 0 holds one 4-bit field per domain, at bits [4d+3:4d], with d = 0 CPU, 1 high-speed bus, 2 peripheral A, 3 peripheral B. Bit 4d+3 enables division and bits [4d+2:4d] give SEL. A dividing domain pulses once every 2^(SEL+1) main ticks (period 2 to 256), and on every pulse of a dividing domain all faster domains pulse too.
- R4: Bit 0 of address 1 selects the PLL tick (1) or the oscillator tick (0) as the main tick, and it reads back as written.
- R5: A divide-control write is refused when the effective exponent (0 when undivided, SEL+1 when dividing) of the high-speed bus is below that of the CPU, or when either peripheral bus's exponent is below that of the high-speed bus. A refused write leaves the control unchanged and sets the error flag at bit 1 of address 1. Equal exponents are accepted.
- R6: The error flag stays set until software writes address 1 with bit 1 set. Writing address 1 with bit 1 clear leaves the flag set.
- R7: Mask registers at addresses 2+d hold one enable bit per module. `mod_en[32d+n]` equals `dom_en[d]` AND mask bit n of domain d.
- R8: A new divide control reads back at once but only governs the outputs after the first main tick on which the shared counter is zero. Until then the previous ratio stays in force.
- R9: The shared counter holds while the selected main tick is low, so the phase of every domain resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Main-clock qualifier from the oscillator path |
| pll_tick | input | 1 | Main-clock qualifier from the PLL path |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dom_en | output | 4 | Domain enable pulses: CPU, high-speed bus, peripheral A, peripheral B |
| mod_en | output | 128 | Per-module enables, 32 per domain, domain d at [32d+31:32d] |

## Verification
The divider is run with a mixed setting in which each domain uses a different ratio (1, 2, 8 and 256), so that the measured pulse periods separate a wrong exponent, a wrong field position and an off-by-one in the counter window. Phase alignment is checked at the slowest domain's pulse. Stopping the main tick for several cycles shows whether the counter really holds rather than free-running. A switch from the slowest common ratio to the fastest one, issued just after a boundary, shows whether the new value waits for the next counter-zero point or takes effect at once. Illegal ratio writes on two different parent/child pairs, followed by an equal-exponent legal write, separate a correct nesting check from one that compares the wrong domains or uses a strict inequality.

// File: rtl/psc_pkg.sv
package psc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Number of synchronous domains and their index order (also field order).
    localparam int NUM_DOM = 4;
    localparam int DOM_CPU = 0;
    localparam int DOM_HSB = 1;
    localparam int DOM_PBA = 2;
    localparam int DOM_PBB = 3;

    // Register addresses.
    localparam int A_DIV   = 0;
    localparam int A_SRC   = 1;
    localparam int A_MASK0 = 2;

    // Parent domain used by the nesting rule (the root returns itself).
    function automatic int dom_parent(input int d);
        case (d)
            DOM_HSB:          return DOM_CPU;
            DOM_PBA, DOM_PBB: return DOM_HSB;
            default:          return DOM_CPU;
        endcase
    endfunction
endpackage

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int MASK_W = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    localparam int FLD_W  = SEL_W + 1,
    localparam int CTRL_W = NUM_DOM * FLD_W,
    localparam int EXP_W  = SEL_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [CTRL_W-1:0]         ctrl_pend,
    output logic                      use_pll,
    output logic                      nest_err,
    output logic [NUM_DOM*MASK_W-1:0] mask_flat
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [CTRL_W-1:0]                ctrl;
        logic                             use_pll;
        logic                             err;
        logic [NUM_DOM-1:0][MASK_W-1:0]   mask;
    } regs_t;

    regs_t cur_q, nxt_d;

    // Effective log2 of the division: 0 when bypassed, SEL+1 when dividing.
    function automatic logic [EXP_W-1:0] fld_exp(input logic [FLD_W-1:0] f);
        if (f[FLD_W-1]) return EXP_W'(f[SEL_W-1:0]) + EXP_W'(1);
        return '0;
    endfunction

    // No child may run faster (smaller exponent) than its parent.
    function automatic logic nest_ok(input logic [CTRL_W-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int d = 1; d < NUM_DOM; d++) begin
            if (fld_exp(c[d*FLD_W +: FLD_W]) < fld_exp(c[dom_parent(d)*FLD_W +: FLD_W]))
                ok = 1'b0;
        end
        return ok;
    endfunction

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            if (addr == ADDR_W'(A_DIV)) begin
                if (nest_ok(wdata[CTRL_W-1:0])) nxt_d.ctrl = wdata[CTRL_W-1:0];
                else                            nxt_d.err  = 1'b1;
            end
            if (addr == ADDR_W'(A_SRC)) begin
                nxt_d.use_pll = wdata[0];
                if (wdata[1]) nxt_d.err = 1'b0;
            end
            for (int d = 0; d < NUM_DOM; d++) begin
                if (addr == ADDR_W'(A_MASK0 + d)) nxt_d.mask[d] = wdata[MASK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ctrl    <= '0;
            cur_q.use_pll <= 1'b0;
            cur_q.err     <= 1'b0;
            cur_q.mask    <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_DIV)) rdata[CTRL_W-1:0] = cur_q.ctrl;
        if (addr == ADDR_W'(A_SRC)) rdata[1:0]        = {cur_q.err, cur_q.use_pll};
        for (int d = 0; d < NUM_DOM; d++) begin
            if (addr == ADDR_W'(A_MASK0 + d)) rdata[MASK_W-1:0] = cur_q.mask[d];
        end
    end

    assign ctrl_pend = cur_q.ctrl;
    assign use_pll   = cur_q.use_pll;
    assign nest_err  = cur_q.err;
    assign mask_flat = cur_q.mask;
endmodule

// File: rtl/psc_div.sv
module psc_div
    import psc_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int FLD_W  = SEL_W + 1,
    localparam int CTRL_W = NUM_DOM * FLD_W,
    localparam int CNT_W  = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [CTRL_W-1:0]  ctrl_pend,
    output logic [CTRL_W-1:0]  ctrl_act,
    output logic [CNT_W-1:0]   cnt,
    output logic [NUM_DOM-1:0] dom_en
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] act;
    } div_t;

    div_t cur_q, nxt_d;

    // Shared counter; ratio changes are adopted only on a zero-count tick.
    always_comb begin
        nxt_d = cur_q;
        if (tick) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
            if (cur_q.cnt == '0) nxt_d.act = ctrl_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cnt <= '0;
            cur_q.act <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [FLD_W-1:0] fld;
        logic [SEL_W:0]   shamt;
        logic [CNT_W-1:0] win;
        assign fld   = cur_q.act[d*FLD_W +: FLD_W];
        assign shamt = {1'b0, fld[SEL_W-1:0]} + (SEL_W+1)'(1);
        assign win   = ~({CNT_W{1'b1}} << shamt);
        assign dom_en[d] = tick & (~fld[FLD_W-1] | ((cur_q.cnt & win) == '0));
    end

    assign ctrl_act = cur_q.act;
    assign cnt      = cur_q.cnt;
endmodule

// File: rtl/psc_gate.sv
module psc_gate
    import psc_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic [NUM_DOM-1:0]        dom_en,
    input  logic [NUM_DOM*MASK_W-1:0] mask,
    output logic [NUM_DOM*MASK_W-1:0] mod_en
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign mod_en[d*MASK_W +: MASK_W] = mask[d*MASK_W +: MASK_W] & {MASK_W{dom_en[d]}};
    end
endmodule

// File: rtl/sync_clk_prescaler.sv
module sync_clk_prescaler
    import psc_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int MASK_W = 32,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      osc_tick,
    input  logic                      pll_tick,
    input  logic                      reg_wr,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [NUM_DOM-1:0]        dom_en,
    output logic [NUM_DOM*MASK_W-1:0] mod_en
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CTRL_W = NUM_DOM * (SEL_W + 1);
    localparam int CNT_W  = 1 << SEL_W;

    logic                      use_pll;
    logic                      nest_err;
    logic                      main_tick;
    logic [CTRL_W-1:0]         ctrl_pend;
    logic [CTRL_W-1:0]         ctrl_act;
    logic [CNT_W-1:0]          div_cnt;
    logic [NUM_DOM*MASK_W-1:0] mask_flat;

    assign main_tick = use_pll ? pll_tick : osc_tick;

    psc_regs #(
        .SEL_W(SEL_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .ctrl_pend(ctrl_pend), .use_pll(use_pll), .nest_err(nest_err),
        .mask_flat(mask_flat)
    );

    psc_div #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(main_tick),
        .ctrl_pend(ctrl_pend), .ctrl_act(ctrl_act), .cnt(div_cnt), .dom_en(dom_en)
    );

    psc_gate #(.MASK_W(MASK_W)) u_gate (
        .dom_en(dom_en), .mask(mask_flat), .mod_en(mod_en)
    );
endmodule

// File: rtl/psc_chk.sv
module psc_chk
    import psc_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int MASK_W = 32,
    parameter int ADDR_W = 3,
    localparam int CTRL_W = NUM_DOM * (SEL_W + 1),
    localparam int CNT_W  = 1 << SEL_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      osc_tick,
    input logic                      pll_tick,
    input logic                      use_pll,
    input logic                      main_tick,
    input logic                      reg_wr,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic                      clr_bit,
    input logic                      nest_err,
    input logic [CTRL_W-1:0]         ctrl_pend,
    input logic [CTRL_W-1:0]         ctrl_act,
    input logic [CNT_W-1:0]          div_cnt,
    input logic [NUM_DOM-1:0]        dom_en,
    input logic [NUM_DOM*MASK_W-1:0] mod_en
);
    timeunit 1ns;
    timeprecision 1ps;

    // R2
    dom_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dom_en) |-> main_tick);

    // R4
    osc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_pll && !osc_tick) |-> (dom_en == '0));

    // R4
    pll_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_pll && !pll_tick) |-> (dom_en == '0));

    // R3
    hsb_under_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_en[DOM_HSB] |-> dom_en[DOM_CPU]);

    // R3
    pba_under_hsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_en[DOM_PBA] |-> dom_en[DOM_HSB]);

    // R3
    pbb_under_hsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_en[DOM_PBB] |-> dom_en[DOM_HSB]);

    // R5
    ctrl_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_pend) |-> $past(reg_wr && reg_addr == ADDR_W'(A_DIV)));

    // R5
    err_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nest_err) |-> $past(reg_wr && reg_addr == ADDR_W'(A_DIV)));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_err && !(reg_wr && reg_addr == ADDR_W'(A_SRC) && clr_bit)) |=> nest_err);

    // R8
    ratio_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_act) |-> $past(main_tick && div_cnt == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_tick |=> $stable(div_cnt));

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_gate
        // R7
        idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dom_en[d] |-> (mod_en[d*MASK_W +: MASK_W] == '0));
    end
endmodule

bind sync_clk_prescaler psc_chk #(
    .SEL_W(SEL_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W)
) u_psc_chk (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
    .use_pll(use_pll), .main_tick(main_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .clr_bit(reg_wdata[1]), .nest_err(nest_err), .ctrl_pend(ctrl_pend),
    .ctrl_act(ctrl_act), .div_cnt(div_cnt), .dom_en(dom_en), .mod_en(mod_en)
);

// File: tb/sync_clk_prescaler_bench.sv
module sync_clk_prescaler_bench;
    timeunit 1ns;
    timeprecision 1ps;
    import psc_pkg::*;

    localparam int SEL_W  = 3;
    localparam int MASK_W = 32;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      osc_tick = 1'b1;
    logic                      pll_tick = 1'b0;
    logic                      reg_wr = 1'b0;
    logic [ADDR_W-1:0]         reg_addr = '0;
    logic [DATA_W-1:0]         reg_wdata = '0;
    logic [DATA_W-1:0]         reg_rdata;
    logic [NUM_DOM-1:0]        dom_en;
    logic [NUM_DOM*MASK_W-1:0] mod_en;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    sync_clk_prescaler #(
        .SEL_W(SEL_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_sync_clk_prescaler (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dom_en(dom_en), .mod_en(mod_en)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end 1 ns after a falling edge.
    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic reg_write(input int a, input logic [DATA_W-1:0] d);
        reg_wr    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input int a, output logic [DATA_W-1:0] d);
        reg_addr = ADDR_W'(a);
        #0.1;
        d = reg_rdata;
    endtask

    task automatic wait_pulse(input int d);
        int k = 0;
        while (!dom_en[d] && k < 700) begin
            step(1);
            k++;
        end
    endtask

    task automatic gap_here(input int d, output int n);
        n = 1;
        while (!dom_en[d] && n < 700) begin
            step(1);
            n++;
        end
    endtask

    task automatic period_of(input int d, output int n);
        wait_pulse(d);
        step(1);
        gap_here(d, n);
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] r;
        check("R1", "dom_en after reset", 64'(dom_en), 64'hF);
        check("R1", "mod_en low half after reset", mod_en[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1", "mod_en high half after reset", mod_en[127:64], 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(A_DIV, r);  check("R1", "divide control reset", 64'(r), 64'h0);
        reg_read(A_SRC, r);  check("R1", "source/status reset", 64'(r), 64'h0);
        for (int d = 0; d < NUM_DOM; d++) begin
            reg_read(A_MASK0 + d, r);
            check("R1", "mask reset", 64'(r), 64'hFFFF_FFFF);
        end
    endtask

    task automatic t_undivided;
        for (int i = 0; i < 6; i++) begin
            step(1);
            check("R2", "undivided pulses every tick", 64'(dom_en), 64'hF);
        end
        osc_tick = 1'b0;
        #1;
        check("R2", "no pulse without main tick", 64'(dom_en), 64'h0);
        osc_tick = 1'b1;
        #1;
    endtask

    task automatic t_source;
        logic [DATA_W-1:0] r;
        reg_write(A_SRC, 32'h1);
        reg_read(A_SRC, r);
        check("R4", "source select readback", 64'(r), 64'h1);
        check("R4", "PLL selected, PLL tick low", 64'(dom_en), 64'h0);
        pll_tick = 1'b1;
        osc_tick = 1'b0;
        #1;
        check("R4", "PLL selected, PLL tick high", 64'(dom_en), 64'hF);
        reg_write(A_SRC, 32'h0);
        check("R4", "oscillator selected, osc tick low", 64'(dom_en), 64'h0);
        osc_tick = 1'b1;
        pll_tick = 1'b0;
        #1;
        check("R4", "oscillator selected, osc tick high", 64'(dom_en), 64'hF);
    endtask

    task automatic t_divided;
        int n;
        logic [DATA_W-1:0] r;
        // CPU undivided, HSB /2, PBA /8, PBB /256
        reg_write(A_DIV, 32'hFA80);
        reg_read(A_DIV, r);
        check("R3", "mixed ratio readback", 64'(r), 64'hFA80);
        step(600);
        period_of(DOM_CPU, n); check("R3", "CPU period", 64'(n), 64'd1);
        period_of(DOM_HSB, n); check("R3", "HSB period", 64'(n), 64'd2);
        period_of(DOM_PBA, n); check("R3", "PBA period", 64'(n), 64'd8);
        period_of(DOM_PBB, n); check("R3", "PBB period", 64'(n), 64'd256);
        wait_pulse(DOM_PBB);
        check("R3", "all domains aligned at slowest pulse", 64'(dom_en), 64'hF);
    endtask

    task automatic t_nesting;
        int n;
        logic [DATA_W-1:0] r;
        reg_write(A_DIV, 32'hFA09);   // HSB faster than CPU
        reg_read(A_DIV, r);
        check("R5", "HSB-faster-than-CPU write refused", 64'(r), 64'hFA80);
        reg_read(A_SRC, r);
        check("R5", "error flag set", 64'(r), 64'h2);
        reg_write(A_DIV, 32'h0A80);   // PBB faster than HSB
        reg_read(A_DIV, r);
        check("R5", "PBB-faster-than-HSB write refused", 64'(r), 64'hFA80);
        step(600);
        period_of(DOM_HSB, n);
        check("R5", "HSB period unchanged after refused write", 64'(n), 64'd2);
    endtask

    task automatic t_sticky;
        logic [DATA_W-1:0] r;
        reg_write(A_SRC, 32'h0);
        reg_read(A_SRC, r);
        check("R6", "error survives write without clear bit", 64'(r), 64'h2);
        reg_write(A_SRC, 32'h2);
        reg_read(A_SRC, r);
        check("R6", "error cleared by write-one", 64'(r), 64'h0);
    endtask

    task automatic t_masks;
        logic [DATA_W-1:0] r;
        reg_write(A_MASK0 + DOM_PBA, 32'h0000_00F0);
        reg_read(A_MASK0 + DOM_PBA, r);
        check("R7", "PBA mask readback", 64'(r), 64'hF0);
        wait_pulse(DOM_PBA);
        check("R7", "PBA gated enables on pulse", 64'(mod_en[64 +: 32]), 64'hF0);
        check("R7", "CPU enables on PBA pulse", 64'(mod_en[0 +: 32]), 64'hFFFF_FFFF);
        step(1);
        check("R7", "PBA enables off between pulses", 64'(mod_en[64 +: 32]), 64'h0);
        check("R7", "CPU enables between PBA pulses", 64'(mod_en[0 +: 32]), 64'hFFFF_FFFF);
        reg_write(A_MASK0 + DOM_PBB, 32'h0);
        wait_pulse(DOM_PBB);
        check("R7", "PBB fully masked on pulse", 64'(mod_en[96 +: 32]), 64'h0);
        check("R7", "PBA mask kept on PBB pulse", 64'(mod_en[64 +: 32]), 64'hF0);
    endtask

    task automatic t_hold;
        wait_pulse(DOM_HSB);
        step(1);
        osc_tick = 1'b0;
        #1;
        for (int i = 0; i < 5; i++) begin
            check("R9", "no pulses while tick stopped", 64'(dom_en), 64'h0);
            step(1);
        end
        osc_tick = 1'b1;
        #1;
        check("R9", "HSB phase held (odd count)", 64'(dom_en[DOM_HSB]), 64'h0);
        check("R9", "CPU resumes at once", 64'(dom_en[DOM_CPU]), 64'h1);
        step(1);
        check("R9", "HSB pulses on following tick", 64'(dom_en[DOM_HSB]), 64'h1);
    endtask

    task automatic t_boundary;
        int n;
        logic [DATA_W-1:0] r;
        reg_write(A_DIV, 32'hFFFF);   // every domain /256, equal exponents
        step(600);
        period_of(DOM_CPU, n);
        check("R5", "equal exponents accepted", 64'(n), 64'd256);
        reg_write(A_DIV, 32'h8888);   // written right after a boundary pulse
        reg_read(A_DIV, r);
        check("R8", "new ratio reads back at once", 64'(r), 64'h8888);
        gap_here(DOM_CPU, n);
        check("R8", "old ratio kept until counter zero", 64'(n), 64'd256);
        step(1);
        gap_here(DOM_CPU, n);
        check("R8", "new ratio after boundary", 64'(n), 64'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_undivided;
        t_source;
        t_divided;
        t_nesting;
        t_sticky;
        t_masks;
        t_hold;
        t_boundary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule